// File: doc/BRIEF.md
# Programmable Bus Wait-State Calculator

This block works out the number of bus cycles that a memory access, or a burst of accesses, costs on a system whose memory regions have different speeds. A request gives the access address, the access width (halfword or word), whether the burst continues a sequential stream, and the number of accesses in the burst. The block answers with a saturated 8-bit cycle total, registered, one clock after the request.

The region is picked from the top address byte. Most regions have a fixed cost per access. Three cartridge ROM windows and the cartridge SRAM region take their timing from a 16-bit wait control word that software loads through a write strobe. Each ROM window has its own first-access cost and its own sequential cost. A word access to a region with a halfword bus is charged as two halfword accesses.

Top module: `wait_cost_calc`

## Requirements
- R1: When `req_valid` is high at a rising edge, `cost_valid` is high in the following cycle and `cost_cycles` holds that request's cost. When `req_valid` is low at an edge, `cost_valid` is low in the following cycle.
- R2: After reset, `cost_valid` is 0 and `cost_cycles` is 0. While no request is presented, `cost_cycles` keeps its last value.
- R3: A high `cfg_wr` loads `cfg_data` into the wait control word at the edge. A request presented in the same cycle as a write is costed with the old word. The reset value of the word is 0, which gives first cost 5 for the SRAM region and all ROM windows, and sequential costs 3, 5 and 9 for windows 0, 1 and 2.
- R4: A 2-bit first-access code maps 0, 1, 2, 3 to 5, 4, 3, 9 cycles. Control bits [1:0] set the SRAM region (0x0E), bits [3:2] set window 0, bits [6:5] set window 1 and bits [9:8] set window 2.
- R5: Control bit 4 set gives window 0 a sequential cost of 2 (3 when clear). Bit 7 gives window 1 a cost of 2 (5 when clear). Bit 10 gives window 2 a cost of 2 (9 when clear). Bits [15:11] have no effect on any cost.
- R6: The region is `req_addr[31:24]`. Regions 0x08 and 0x09 use window 0, 0x0A and 0x0B use window 1, and 0x0C and 0x0D use window 2. The lower 24 address bits have no effect.
- R7: The fixed first costs are 1 for region 0x00, 0 for 0x01, 3 for 0x02, and 1 for 0x03 to 0x07. Every region from 0x0F up costs 1 per halfword access.
- R8: Regions 0x00, 0x03, 0x04 and 0x07 have a word-wide bus and cost first × count, whatever the width and the sequential flag.
- R9: A non-sequential ROM burst costs first + seq × (beats − 1), where beats is count for halfword access (`req_wide`=0) and 2 × count for word access (`req_wide`=1).
- R10: A sequential ROM burst costs seq × beats.
- R11: Every other region (0x01, 0x02, 0x05, 0x06, 0x0E and all regions from 0x0F up) costs first × beats, whatever the sequential flag.
- R12: A count of 0 costs 0. A total above 255 is reported as 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the wait control word |
| cfg_data | input | 16 | New wait control word |
| req_valid | input | 1 | A cost request is presented |
| req_addr | input | 32 | Access address; bits [31:24] pick the region |
| req_wide | input | 1 | 1 = word access, 0 = halfword access |
| req_seq | input | 1 | 1 = sequential burst, 0 = non-sequential |
| req_count | input | COUNT_W | Number of accesses in the burst |
| cost_valid | output | 1 | `cost_cycles` answers the previous cycle's request |
| cost_cycles | output | COST_W | Saturated cycle total |

## Verification
The bench builds the block with its default parameters: a 4-bit count and an 8-bit result. With these values every count from 0 to 15 can be swept, and word bursts on slow regions such as window 2 (9 × 30 cycles) pass 255, so both the saturation and the exact values below it are exercised. For each of several control words, covering every first-access code and both sequential settings, the sweep runs every region from 0x00 to 0x0F plus two high regions, both widths and both sequential settings. Separate checks cover a write in the same cycle as a request, and the control bits and address bits that must have no effect.

// File: rtl/wait_cost_pkg.sv
package wait_cost_pkg;

  localparam int CTRL_W = 16;
  localparam int CYC_W  = 4;

  typedef struct packed {
    logic [CYC_W-1:0] first;   // cost of a non-sequential access
    logic [CYC_W-1:0] seq;     // cost of a sequential access (ROM only)
    logic             wide_bus; // region bus carries a word per access
    logic             is_rom;  // region uses a ROM window's timing
  } region_timing_t;

  function automatic logic [CYC_W-1:0] first_code_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return CYC_W'(5);
      2'd1:    return CYC_W'(4);
      2'd2:    return CYC_W'(3);
      default: return CYC_W'(9);
    endcase
  endfunction

endpackage

// File: rtl/wait_ctrl_reg.sv
module wait_ctrl_reg
  import wait_cost_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/region_timing_lookup.sv
module region_timing_lookup
  import wait_cost_pkg::*;
(
  input  logic [7:0]        region,
  input  logic [CTRL_W-1:0] ctrl,
  output region_timing_t    timing
);

  localparam int NUM_WIN = 3;

  logic [CYC_W-1:0] win_first [0:3];
  logic [CYC_W-1:0] win_seq   [0:3];
  logic             unused_ctrl_hi;

  assign unused_ctrl_hi = ^ctrl[CTRL_W-1:11];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int FIRST_LSB = 2 + 3*w;
    localparam int SEQ_BIT   = 4 + 3*w;
    localparam int SLOW_SEQ  = (w == 0) ? 3 : ((w == 1) ? 5 : 9);
    assign win_first[w] = first_code_cycles(ctrl[FIRST_LSB +: 2]);
    assign win_seq[w]   = ctrl[SEQ_BIT] ? CYC_W'(2) : CYC_W'(SLOW_SEQ);
  end
  assign win_first[3] = '0;
  assign win_seq[3]   = '0;

  always_comb begin
    timing.first    = CYC_W'(1);
    timing.seq      = '0;
    timing.wide_bus = 1'b0;
    timing.is_rom   = 1'b0;
    case (region)
      8'h00: timing.wide_bus = 1'b1;
      8'h01: timing.first = '0;
      8'h02: timing.first = CYC_W'(3);
      8'h03, 8'h04, 8'h07: timing.wide_bus = 1'b1;
      8'h05, 8'h06: ;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: begin
        timing.is_rom = 1'b1;
        timing.first  = win_first[region[2:1]];
        timing.seq    = win_seq[region[2:1]];
      end
      8'h0E: timing.first = first_code_cycles(ctrl[1:0]);
      default: ;
    endcase
  end

endmodule

// File: rtl/burst_cost_engine.sv
module burst_cost_engine
  import wait_cost_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int COST_W  = 8
) (
  input  region_timing_t      timing,
  input  logic                wide,
  input  logic                seq,
  input  logic [COUNT_W-1:0]  count,
  output logic [COST_W-1:0]   cost
);

  localparam int BEAT_W = COUNT_W + 1;
  localparam int FULL_W = COUNT_W + COST_W + CYC_W + 2;
  localparam logic [FULL_W-1:0] COST_MAX = FULL_W'((64'd1 << COST_W) - 1);

  logic [FULL_W-1:0] n_ext, beats, first_ext, seq_ext, full;

  always_comb begin
    n_ext     = FULL_W'(count);
    beats     = wide ? FULL_W'({count, 1'b0}) : FULL_W'({1'b0, count});
    first_ext = FULL_W'(timing.first);
    seq_ext   = FULL_W'(timing.seq);
    if (count == '0)              full = '0;
    else if (timing.wide_bus)     full = first_ext * n_ext;
    else if (timing.is_rom && seq) full = seq_ext * beats;
    else if (timing.is_rom)       full = first_ext + seq_ext * (beats - FULL_W'(1));
    else                          full = first_ext * beats;
    cost = (full > COST_MAX) ? COST_MAX[COST_W-1:0] : full[COST_W-1:0];
  end

  initial begin
    if (BEAT_W > FULL_W) $error("burst_cost_engine: width setup");
  end

endmodule

// File: rtl/wait_cost_calc.sv
module wait_cost_calc
  import wait_cost_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int COST_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [15:0]        cfg_data,
  input  logic               req_valid,
  input  logic [31:0]        req_addr,
  input  logic               req_wide,
  input  logic               req_seq,
  input  logic [COUNT_W-1:0] req_count,
  output logic               cost_valid,
  output logic [COST_W-1:0]  cost_cycles
);

  logic [CTRL_W-1:0]  ctrl_word;
  region_timing_t     timing;
  logic [COST_W-1:0]  cost_comb;
  logic               valid_d;
  logic [COST_W-1:0]  cycles_d;
  logic               unused_addr_lo;

  assign unused_addr_lo = ^req_addr[23:0];

  wait_ctrl_reg i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_data),
    .ctrl_q  (ctrl_word)
  );

  region_timing_lookup i_lookup (
    .region (req_addr[31:24]),
    .ctrl   (ctrl_word),
    .timing (timing)
  );

  burst_cost_engine #(
    .COUNT_W (COUNT_W),
    .COST_W  (COST_W)
  ) i_engine (
    .timing (timing),
    .wide   (req_wide),
    .seq    (req_seq),
    .count  (req_count),
    .cost   (cost_comb)
  );

  always_comb begin
    valid_d  = req_valid;
    cycles_d = cost_cycles;
    if (req_valid) cycles_d = cost_comb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_valid  <= 1'b0;
      cost_cycles <= '0;
    end else begin
      cost_valid  <= valid_d;
      cost_cycles <= cycles_d;
    end
  end

endmodule

// File: rtl/wait_cost_calc_chk.sv
module wait_cost_calc_chk #(
  parameter int COUNT_W = 4,
  parameter int COST_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic               req_wide,
  input logic               req_seq,
  input logic [COUNT_W-1:0] req_count,
  input logic               cost_valid,
  input logic [COST_W-1:0]  cost_cycles,
  input logic [15:0]        ctrl_word
);

  assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> cost_valid);

  assert_valid_drops_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !cost_valid);

  assert_idle_holds_cost_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(cost_cycles));

  assert_wide_bus_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:24] == 8'h04) |=> cost_cycles == COST_W'($past(req_count)));

  assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_count == '0) |=> cost_cycles == '0);

  assert_free_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:24] == 8'h01) |=> cost_cycles == '0);

  assert_win0_seq_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seq && !req_wide && req_count == COUNT_W'(1) &&
     req_addr[31:24] == 8'h08)
    |=> cost_cycles == ($past(ctrl_word[4]) ? COST_W'(2) : COST_W'(3)));

endmodule

bind wait_cost_calc wait_cost_calc_chk #(
  .COUNT_W (COUNT_W),
  .COST_W  (COST_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_wide    (req_wide),
  .req_seq     (req_seq),
  .req_count   (req_count),
  .cost_valid  (cost_valid),
  .cost_cycles (cost_cycles),
  .ctrl_word   (ctrl_word)
);

// File: tb/test_wait_cost_calc.sv
module test_wait_cost_calc;

  localparam int CLK_PERIOD = 10;
  localparam int COUNT_W = 4;
  localparam int COST_W  = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_wr;
  logic [15:0]        cfg_data;
  logic               req_valid;
  logic [31:0]        req_addr;
  logic               req_wide;
  logic               req_seq;
  logic [COUNT_W-1:0] req_count;
  logic               cost_valid;
  logic [COST_W-1:0]  cost_cycles;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] model_cfg = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_cost_calc #(.COUNT_W(COUNT_W), .COST_W(COST_W)) i_wait_cost_calc (
    .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_data (cfg_data),
    .req_valid (req_valid), .req_addr (req_addr), .req_wide (req_wide),
    .req_seq (req_seq), .req_count (req_count),
    .cost_valid (cost_valid), .cost_cycles (cost_cycles)
  );

  function automatic int code_cost(input int code);
    case (code & 3)
      0: return 5;
      1: return 4;
      2: return 3;
      default: return 9;
    endcase
  endfunction

  function automatic int raw_cost(input logic [15:0] cfg, input int region,
                                  input bit wide, input bit seq, input int cnt);
    int first, sq, beats;
    bit rom, wbus;
    rom = 0; wbus = 0; first = 1; sq = 0;
    beats = wide ? 2*cnt : cnt;
    if (region == 0 || region == 3 || region == 4 || region == 7) wbus = 1;
    else if (region == 1) first = 0;
    else if (region == 2) first = 3;
    else if (region >= 8 && region <= 13) begin
      rom = 1;
      case ((region - 8) / 2)
        0: begin first = code_cost(cfg[3:2]); sq = cfg[4]  ? 2 : 3; end
        1: begin first = code_cost(cfg[6:5]); sq = cfg[7]  ? 2 : 5; end
        default: begin first = code_cost(cfg[9:8]); sq = cfg[10] ? 2 : 9; end
      endcase
    end else if (region == 14) first = code_cost(cfg[1:0]);
    if (cnt == 0) return 0;
    if (wbus) return first * cnt;
    if (rom && seq) return sq * beats;
    if (rom) return first + sq * (beats - 1);
    return first * beats;
  endfunction

  function automatic string tag_of(input int region, input bit seq, input int cnt, input int raw);
    if (cnt == 0 || raw > 255) return "R12";
    if (region == 0 || region == 3 || region == 4 || region == 7) return "R8";
    if (region >= 8 && region <= 13) return seq ? "R10" : "R9";
    return "R11";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one request, then sample one cycle later away from the edge.
  task automatic cost_req(input string req, input logic [31:0] addr, input bit wide,
                          input bit seq, input int cnt, input int exp);
    req_valid = 1'b1; req_addr = addr; req_wide = wide; req_seq = seq;
    req_count = COUNT_W'(cnt);
    @(negedge clk);
    chk(req, int'(cost_valid), 1);
    chk(req, int'(cost_cycles), exp);
    req_valid = 1'b0;
  endtask

  task automatic write_cfg(input logic [15:0] v);
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_cfg = v;
  endtask

  task automatic idle_check(input int last);
    req_valid = 1'b0; req_addr = 32'h0E00_0000; req_count = 4'd7;
    @(negedge clk);
    chk("R1", int'(cost_valid), 0);
    chk("R2", int'(cost_cycles), last);
  endtask

  task automatic sweep();
    int last;
    last = 0;
    for (int r = 0; r < 18; r++) begin
      int region;
      region = (r < 16) ? r : ((r == 16) ? 8'h20 : 8'hFF);
      for (int w = 0; w < 2; w++) begin
        for (int s = 0; s < 2; s++) begin
          for (int c = 0; c < 16; c++) begin
            int raw, ex;
            raw = raw_cost(model_cfg, region, bit'(w), bit'(s), c);
            ex = (raw > 255) ? 255 : raw;
            cost_req(tag_of(region, bit'(s), c, raw),
                     {8'(region), 24'(c * 24'h01_0101 + r)}, bit'(w), bit'(s), c, ex);
            last = ex;
          end
        end
      end
    end
    idle_check(last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = '0; req_valid = 1'b0;
    req_addr = '0; req_wide = 1'b0; req_seq = 1'b0; req_count = '0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2", int'(cost_valid), 0);
    chk("R2", int'(cost_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(cost_valid), 0);

    // R3: default timing after reset
    cost_req("R3", 32'h0E00_0000, 1'b0, 1'b0, 1, 5);
    cost_req("R3", 32'h0C00_0000, 1'b0, 1'b1, 1, 9);
    cost_req("R3", 32'h0A00_0000, 1'b0, 1'b0, 2, 10);

    // R7: fixed per-region costs, one halfword access
    cost_req("R7", 32'h0000_0000, 1'b0, 1'b0, 1, 1);
    cost_req("R7", 32'h0100_0000, 1'b0, 1'b0, 1, 0);
    cost_req("R7", 32'h0200_0000, 1'b0, 1'b0, 1, 3);
    cost_req("R7", 32'h0600_0000, 1'b0, 1'b0, 1, 1);
    cost_req("R7", 32'h4000_0000, 1'b0, 1'b0, 3, 3);

    // R3: request in the same cycle as a write sees the old word
    cfg_wr = 1'b1; cfg_data = 16'h0003;
    req_valid = 1'b1; req_addr = 32'h0E00_0000; req_wide = 1'b0; req_seq = 1'b0;
    req_count = 4'd1;
    @(negedge clk);
    cfg_wr = 1'b0; model_cfg = 16'h0003;
    chk("R3", int'(cost_cycles), 5);
    cost_req("R3", 32'h0E00_0000, 1'b0, 1'b0, 1, 9);
    // R4: SRAM and window code decode
    write_cfg(16'h0001);
    cost_req("R4", 32'h0E00_0000, 1'b0, 1'b0, 1, 4);
    write_cfg(16'h0108);
    cost_req("R4", 32'h0800_0000, 1'b0, 1'b0, 1, 3);
    cost_req("R4", 32'h0D00_0000, 1'b0, 1'b0, 1, 4);
    // R6: paired regions share a window; low address bits ignored
    cost_req("R6", 32'h09AB_CDEF, 1'b0, 1'b0, 1, 3);
    cost_req("R6", 32'h0B12_3456, 1'b0, 1'b0, 1, 5);
    // R5: upper control bits change nothing
    write_cfg(16'hF800);
    cost_req("R5", 32'h0800_0000, 1'b0, 1'b1, 3, 9);
    cost_req("R5", 32'h0E00_0000, 1'b0, 1'b0, 1, 5);
    write_cfg(16'h0490);
    cost_req("R5", 32'h0800_0000, 1'b0, 1'b1, 3, 6);
    cost_req("R5", 32'h0A00_0000, 1'b1, 1'b1, 2, 8);

    // Sweeps: every first-code value with both sequential settings
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      int c;
      c = k & 3;
      v = 16'(c | (c << 2) | (c << 5) | (c << 8));
      if (k >= 4) v = v | 16'h0490;
      if (k == 5) v = v | 16'hF800;
      write_cfg(v);
      sweep();
    end
    write_cfg(16'h0164);
    sweep();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule